// File: doc/BRIEF.md
# Up/Down Counter with Run-Time Wrap or Clamp

This block is a small synchronous binary counter whose direction and end behaviour are both chosen at run time. One control selects counting up or counting down; the other selects whether the count rolls over at the ends of its range or stops there. Both controls are sampled on the same rising clock edge that updates the count. When either control changes, the counter continues from whatever value it currently holds, following the new mode.

It suits sequencing and pointer logic that sometimes needs a modulo counter and sometimes a bounded one. A synchronous, active-low reset returns the count to zero. The width is a parameter; the default is three bits, giving a range of 0 to 7.

Top module: `updn_wrapclamp_counter`

## Requirements
- R1: When `rst_n` is low at a rising edge of `clk`, `count` is 0 after that edge, whatever the control inputs are.
- R2: With `dir_down` = 0 and `count` below its maximum (all ones), each rising edge adds 1 to `count`, for either value of `clamp_en`.
- R3: With `dir_down` = 1 and `count` above 0, each rising edge subtracts 1 from `count`, for either value of `clamp_en`.
- R4: With `dir_down` = 0 and `clamp_en` = 0, a count at its maximum goes to 0 on the next edge.
- R5: With `dir_down` = 1 and `clamp_en` = 0, a count of 0 goes to its maximum on the next edge.
- R6: With `dir_down` = 0 and `clamp_en` = 1, a count at its maximum stays at its maximum.
- R7: With `dir_down` = 1 and `clamp_en` = 1, a count of 0 stays at 0.
- R8: `dir_down` and `clamp_en` are sampled at the same edge that updates `count`; a change of either takes effect at the first edge after it, starting from the value held at that moment, with no extra cycle of delay.
- R9: `count` is plain binary with bit CNT_W-1 the most significant bit; with the default width, the value 4 appears as `count` = 3'b100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dir_down | input | 1 | 0 counts up, 1 counts down |
| clamp_en | input | 1 | 0 rolls over at the ends, 1 holds at the ends |
| count | output | CNT_W | Current count, binary, MSB first |

## Verification
The bench builds the block at its default width of three bits, so the full range of 0 to 7 is walked end to end in a handful of cycles and both ends are reached repeatedly. At this width every mode pairing can be driven into the top and bottom of the range, and mode switches can be placed right at an end and in the middle of a run, so a delayed or mis-sampled control shows up as a wrong value on the very next edge.

// File: rtl/cnt_pkg.sv
// Package: shared types for the up/down wrap-or-clamp counter.
// Assumes: control inputs are single bits, decoded once at the top.
package cnt_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

    typedef enum logic {
        END_WRAP  = 1'b0,
        END_CLAMP = 1'b1
    } cnt_end_e;

    typedef struct packed {
        cnt_dir_e dir;
        cnt_end_e endm;
    } cnt_mode_t;

endpackage

// File: rtl/cnt_mode_decode.sv
// Module: cnt_mode_decode
// Turns the raw direction and end-behaviour pins into the typed mode
// record used by the next-value logic. Purely combinational.
// Assumes: both pins are already synchronous to clk.
module cnt_mode_decode
    import cnt_pkg::*;
(
    input  logic      dir_down,
    input  logic      clamp_en,
    output cnt_mode_t mode
);

    // Pack the two pins into the mode record.
    always_comb begin
        mode.dir  = dir_down ? DIR_DOWN : DIR_UP;
        mode.endm = clamp_en ? END_CLAMP : END_WRAP;
    end

endmodule

// File: rtl/cnt_next_value.sv
// Module: cnt_next_value
// Computes the count for the next cycle from the present count and the
// mode record: one step in the chosen direction, and at an end either
// roll over or hold depending on the end behaviour.
// Assumes: cur is a plain binary value of W bits.
module cnt_next_value
    import cnt_pkg::*;
#(
    parameter int W = 3
) (
    input  logic [W-1:0] cur,
    input  cnt_mode_t    mode,
    output logic [W-1:0] nxt
);

    localparam logic [W-1:0] TOP  = {W{1'b1}};
    localparam logic [W-1:0] BOT  = '0;
    localparam logic [W-1:0] STEP = W'(1);

    logic at_top;
    logic at_bot;

    // Flag the two ends of the range.
    always_comb begin
        at_top = (cur == TOP);
        at_bot = (cur == BOT);
    end

    // Select step, roll-over or hold.
    always_comb begin
        nxt = cur;
        unique case (mode.dir)
            DIR_UP: begin
                if (!at_top)                nxt = cur + STEP;
                else if (mode.endm == END_WRAP) nxt = BOT;
                else                        nxt = TOP;
            end
            DIR_DOWN: begin
                if (!at_bot)                nxt = cur - STEP;
                else if (mode.endm == END_WRAP) nxt = TOP;
                else                        nxt = BOT;
            end
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/cnt_state_reg.sv
// Module: cnt_state_reg
// Holds the count. Synchronous active-low reset to zero, otherwise
// loads the next value on every rising edge.
// Assumes: d is valid a setup time before each rising edge.
module cnt_state_reg #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Register the count with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (q == '0)); // R1

endmodule

// File: rtl/updn_wrapclamp_counter.sv
// Module: updn_wrapclamp_counter
// Top of the up/down counter with run-time wrap or clamp at the ends.
// Controls are sampled on the same edge that updates the count.
// Assumes: all inputs synchronous to clk; rst_n active low, synchronous.
module updn_wrapclamp_counter
    import cnt_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_down,
    input  logic             clamp_en,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    cnt_mode_t        mode;
    logic [CNT_W-1:0] nxt;

    cnt_mode_decode u_decode (
        .dir_down (dir_down),
        .clamp_en (clamp_en),
        .mode     (mode)
    );

    cnt_next_value #(.W(CNT_W)) u_next (
        .cur  (count),
        .mode (mode),
        .nxt  (nxt)
    );

    cnt_state_reg #(.W(CNT_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nxt),
        .q     (count)
    );

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_down && count != MAXV) |=> count == CNT_W'($past(count) + 1'b1)); // R2
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_down && count != '0) |=> count == CNT_W'($past(count) - 1'b1)); // R3
    AST_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_down && !clamp_en && count == MAXV) |=> count == '0); // R4
    AST_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_down && !clamp_en && count == '0) |=> count == MAXV); // R5
    AST_CLAMP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_down && clamp_en && count == MAXV) |=> $stable(count)); // R6
    AST_CLAMP_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_down && clamp_en && count == '0) |=> $stable(count)); // R7

endmodule

// File: tb/updn_wrapclamp_counter_bench.sv
module updn_wrapclamp_counter_bench;

    localparam int W = 3;
    localparam int NV = 26;
    // Each entry: {dir_down, clamp_en, expected count after the edge}.
    localparam logic [4:0] VEC [NV] = '{
        {2'b00, 3'd1}, {2'b00, 3'd2}, {2'b00, 3'd3}, {2'b00, 3'd4},
        {2'b00, 3'd5}, {2'b00, 3'd6}, {2'b00, 3'd7}, {2'b00, 3'd0},
        {2'b10, 3'd7}, {2'b10, 3'd6}, {2'b01, 3'd7}, {2'b01, 3'd7},
        {2'b11, 3'd6}, {2'b11, 3'd5}, {2'b11, 3'd4}, {2'b11, 3'd3},
        {2'b11, 3'd2}, {2'b11, 3'd1}, {2'b11, 3'd0}, {2'b11, 3'd0},
        {2'b10, 3'd7}, {2'b01, 3'd7}, {2'b10, 3'd6}, {2'b00, 3'd7},
        {2'b00, 3'd0}, {2'b01, 3'd1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         dir_down = 1'b0;
    logic         clamp_en = 1'b0;
    logic [W-1:0] count;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    updn_wrapclamp_counter #(.CNT_W(W)) u_updn_wrapclamp_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir_down (dir_down),
        .clamp_en (clamp_en),
        .count    (count)
    );

    task automatic check(input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: count=%0d expected %0d", tag, act, exp);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check("R1 reset state", count, 3'd0);
        rst_n = 1'b1;
        // Table walk: apply at a falling edge, check at the next one.
        for (int i = 0; i < NV; i++) begin
            dir_down = VEC[i][4];
            clamp_en = VEC[i][3];
            @(negedge clk);
            check($sformatf("R2/R3/R4/R5/R6/R7/R8 vector %0d", i),
                  count, VEC[i][2:0]);
        end
        // Count is 1 here; reset while controls ask to count down.
        dir_down = 1'b1; clamp_en = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset from 1", count, 3'd0);
        @(negedge clk);
        check("R1 reset held, no wrap", count, 3'd0);
        // Release; first edge counts down with wrap from 0.
        rst_n = 1'b1;
        @(negedge clk);
        check("R5 wrap right after reset", count, 3'd7);
        // Mode change at the very next edge: clamp up holds at 7.
        dir_down = 1'b0; clamp_en = 1'b1;
        @(negedge clk);
        check("R8 immediate switch to clamp", count, 3'd7);
        // Down with clamp to 4 and check bit layout.
        dir_down = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 value 4 is 3'b100", count, 3'b100);
        checks++;
        if (count[2] !== 1'b1) begin
            errors++;
            $display("FAIL R9: msb=%0b expected 1", count[2]);
        end
        // Mid-run reverse: one edge later count steps up.
        dir_down = 1'b0; clamp_en = 1'b0;
        @(negedge clk);
        check("R8 mid-run reverse", count, 3'd5);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, count=%0d expected end", count);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule